// File: doc/BRIEF.md
# Reloadable Line-Count Interrupt Timer

This block raises a maskable interrupt request at a programmable spacing in display lines. It counts single-cycle pulses that mark horizontal sync transitions. A programmable down-counter is loaded from a reload register. When the counter runs out, the request line goes high and the counter reloads itself at once. This gives a steady train of requests every N lines.

A frame trigger input is pulsed a fixed number of lines after vertical sync begins. The trigger reloads the full count and starts the counter, so the request train stays aligned with the frame. The counter does nothing until the first trigger after reset.

The request is cleared in either of two ways: by a CPU acknowledge pulse, or by a mode-register write whose data carries the clear code. Neither of these alters the counter. As a result, no minimum spacing is imposed between requests.

A reload value of 0 behaves as a full wrap of the counter width.

Top module: `line_irq_timer`

## Requirements
- R1: After reset `irq` is low and the counter is idle. Line pulses that arrive before the first `frame_trig` never raise `irq`.
- R2: A `frame_trig` pulse loads `reload_val` and starts counting. If `frame_trig` and `line_pulse` arrive in the same cycle, the trigger wins and that line pulse is not counted.
- R3: While the counter runs, each `line_pulse` decrements it. On the Nth line pulse after a load, `irq` is high from the next cycle and the counter reloads `reload_val` by itself. With N=1 a request follows every line; with N=52 a request follows every 52 lines.
- R4: Once raised, `irq` stays high until it is cleared.
- R5: A one-cycle `int_ack` drives `irq` low in the next cycle and leaves the count unchanged. The next request therefore arrives on schedule, even if that is fewer lines away than a full period.
- R6: A `cfg_wr` strobe clears `irq` when `cfg_data[7:6]` is 2'b10 and `cfg_data[4]` is 1. Any other data value has no effect. The count is left unchanged.
- R7: If a new terminal count falls in the same cycle as an acknowledge or a clear write, `irq` stays high.
- R8: A `frame_trig` pulse in the middle of a count restarts the full count from `reload_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pulse | input | 1 | One-cycle pulse per horizontal sync transition |
| frame_trig | input | 1 | One-cycle pulse that reloads the counter and starts it |
| reload_val | input | CNT_W | Lines per request period |
| int_ack | input | 1 | CPU interrupt acknowledge pulse |
| cfg_wr | input | 1 | Mode-register write strobe |
| cfg_data | input | 8 | Mode-register write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses a short period of five lines to check the basic train. The same period then shows that an acknowledge or a clear write in the middle of a period does not restart the count: the next request still arrives on the original schedule and not a full period later. A trigger in the middle of a count, and a trigger in the same cycle as a line pulse, separate a true reload from simple counting. A period of one line and a period of 52 lines cover the two ends of the range. These cases also show that set wins over clear. Clear-code writes with the wrong selector bits, or with the clear bit low, are checked to leave the request high.

// File: rtl/line_irq_timer.sv
module line_irq_timer #(
  parameter int          CNT_W   = 16,
  parameter logic [1:0]  CLR_SEL = 2'b10,
  parameter int          CLR_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_pulse,
  input  logic             frame_trig,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             int_ack,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_data,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  wire clr_hit  = cfg_wr && (cfg_data[7:6] == CLR_SEL) && cfg_data[CLR_BIT];
  wire step     = running && line_pulse && !frame_trig;
  wire terminal = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (frame_trig) begin
      running <= 1'b1;
      cnt     <= reload_val;
    end else if (terminal) begin
      cnt     <= reload_val;
    end else if (step) begin
      cnt     <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                irq <= 1'b0;
    else if (terminal)         irq <= 1'b1;
    else if (int_ack || clr_hit) irq <= 1'b0;
  end
endmodule

module line_irq_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_pulse,
  input logic             frame_trig,
  input logic [CNT_W-1:0] reload_val,
  input logic             int_ack,
  input logic             irq,
  input logic             running,
  input logic [CNT_W-1:0] cnt
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !irq);

  a_r2_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig |=> (cnt == $past(reload_val)) && running);

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && line_pulse && !frame_trig && cnt != CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));

  a_r3_wrap_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (running && line_pulse && !frame_trig && cnt == CNT_W'(1)) |=> irq && (cnt == $past(reload_val)));

  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_pulse) && !$past(frame_trig));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !line_pulse) |=> !irq);

  a_r5_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pulse && !frame_trig) |=> $stable(cnt));
endmodule

bind line_irq_timer line_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .frame_trig(frame_trig),
  .reload_val(reload_val), .int_ack(int_ack), .irq(irq),
  .running(running), .cnt(cnt)
);

// File: tb/tb_line_irq_timer.sv
module tb_line_irq_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_pulse = 1'b0, frame_trig = 1'b0, int_ack = 1'b0, cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [CNT_W-1:0] reload_val = '0;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  line_irq_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .frame_trig(frame_trig),
    .reload_val(reload_val), .int_ack(int_ack), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input logic hs, input logic tr, input logic ak,
                     input logic wr, input logic [7:0] d,
                     input bit e, input string tag);
    @(negedge clk);
    line_pulse = hs; frame_trig = tr; int_ack = ak; cfg_wr = wr; cfg_data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input bit e, input string tag);
    cyc(0, 0, 0, 0, 8'h00, e, tag);
  endtask

  task automatic line(input bit e, input string tag);
    cyc(1, 0, 0, 0, 8'h00, e, tag);
    idle(e, tag);
  endtask

  task automatic lines0(input int n, input string tag);
    for (int i = 0; i < n; i++) line(0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (irq !== e) begin
          n_bad++;
          $display("FAIL %s: irq=%0b expected %0b", t, irq, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    reload_val = 16'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and no requests before the first trigger
    idle(0, "R1 reset");
    lines0(8, "R1 idle lines");
    // R2/R3: trigger then a period of five lines
    cyc(0, 1, 0, 0, 8'h00, 0, "R2 trigger");
    lines0(4, "R3 count");
    line(1, "R3 fifth line");
    // R4: request held
    idle(1, "R4 hold"); idle(1, "R4 hold");
    // R5: acknowledge mid-period leaves the count running
    line(1, "R4 hold across line");
    line(1, "R4 hold across line");
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    lines0(2, "R5 count kept");
    line(1, "R5 on schedule");
    // R6: clear write decode
    cyc(0, 0, 0, 1, 8'hD0, 1, "R6 wrong selector");
    cyc(0, 0, 0, 1, 8'h80, 1, "R6 clear bit low");
    cyc(0, 0, 0, 1, 8'h90, 0, "R6 clear");
    lines0(4, "R6 count kept");
    line(1, "R6 on schedule");
    // R8: mid-count trigger restarts full period
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    lines0(3, "R8 before restart");
    cyc(0, 1, 0, 0, 8'h00, 0, "R8 restart");
    lines0(4, "R8 full period");
    line(1, "R8 after restart");
    // R2: trigger and line pulse in the same cycle
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    lines0(4, "R2 near end");
    cyc(1, 1, 0, 0, 8'h00, 0, "R2 trigger wins");
    idle(0, "R2 trigger wins");
    lines0(4, "R2 full period");
    line(1, "R2 after collision");
    // R3 with period 1, R7 set over clear
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    reload_val = 16'd1;
    cyc(0, 1, 0, 0, 8'h00, 0, "R3 load one");
    line(1, "R3 every line");
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    line(1, "R3 every line");
    cyc(1, 0, 1, 0, 8'h00, 1, "R7 set beats ack");
    cyc(1, 0, 0, 1, 8'h90, 1, "R7 set beats clear");
    cyc(0, 0, 0, 1, 8'h90, 0, "R6 clear");
    // R3 with period 52
    reload_val = 16'd52;
    cyc(0, 1, 0, 0, 8'h00, 0, "R3 load 52");
    lines0(51, "R3 count 52");
    line(1, "R3 line 52");
    cyc(0, 0, 1, 0, 8'h00, 0, "R5 ack");
    lines0(51, "R3 count 52 again");
    line(1, "R3 second line 52");
    idle(1, "R4 hold");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule